// File: doc/BRIEF.md
# Peripheral Idle Timer Monitor

This block keeps one idle countdown per peripheral device so that power-management software can find devices that have gone quiet. Software writes each device's reload value, then sets that device's timer enable. From then on, the countdown steps down once per pulse of a prescaled tick strobe. Activity on the device reloads the count. Activity means an address-range hit, or a DMA acknowledge or general-purpose input event when the matching source enable is set.

When an enabled countdown steps from one to zero, the device's idle status bit is set. The SMI output is the OR of every status bit whose per-device SMI enable is set. The SMI handler reads the status bits to find the idle device, and clears the bit it has handled by pulsing the matching clear input. This block does not power anything down. Hits caused by accesses to external IDE devices on PCI carry a qualifier flag, and such hits never reload a timer.

Top module: `idle_mon`

## Requirements
- R1: A rising edge of a device's timer enable loads that device's reload value. The idle status then sets after exactly that many ticks.
- R2: The count changes only on cycles where `tick_i` is high. With no ticks, no expiry happens, however many clocks pass.
- R3: The tick that takes an enabled count from 1 to 0 sets the device's `idle_sts_o` bit at that same clock edge.
- R4: An address hit on an enabled device reloads its count from the reload value.
- R5: A DMA acknowledge reloads the count only while that device's `dack_en_i` bit is 1. A general-purpose input event reloads it only while `gpi_en_i` is 1. With the enable at 0, the event has no effect on expiry timing.
- R6: An address hit in a cycle where `hit_ext_ide_i` is 1 does not reload any timer.
- R7: A reload event in the same cycle as a tick takes priority: the count becomes the reload value and does not decrement.
- R8: After expiry the count stays at zero. Further ticks produce no new expiry until the count is reloaded or the timer is re-enabled.
- R9: While its enable is 0, a timer is frozen. Ticks and activity do not change it, no expiry occurs, and existing status bits keep their value.
- R10: A status bit stays set until a one is written to the matching bit of `sts_clr_i`. When a clear and a new expiry land in the same cycle, the bit stays set.
- R11: `smi_o` is 1 exactly when some set status bit has its `smi_en_i` bit at 1.
- R12: A reload value of zero never produces an expiry.
- R13: Each device's count, reload and status are independent of every other device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescaled countdown strobe, one clock wide |
| tmr_en_i | input | N_DEV | Per-device timer enable; a rising edge loads the count |
| reload_i | input | N_DEV*CNT_W | Per-device reload values; device k uses bits [k*CNT_W +: CNT_W] |
| smi_en_i | input | N_DEV | Per-device SMI enable |
| hit_i | input | N_DEV | Per-device address-range hit strobe |
| hit_ext_ide_i | input | 1 | Marks this cycle's hits as external PCI IDE accesses, which are ignored |
| dack_i | input | N_DEV | Per-device DMA acknowledge activity |
| dack_en_i | input | N_DEV | Per-device DMA acknowledge reload enable |
| gpi_i | input | N_DEV | Per-device general-purpose input activity |
| gpi_en_i | input | N_DEV | Per-device general-purpose input reload enable |
| sts_clr_i | input | N_DEV | Write-one-to-clear pulse for the idle status bits |
| idle_sts_o | output | N_DEV | Per-device idle status |
| smi_o | output | 1 | System management interrupt request |

## Verification
The bench builds the block with three devices and a 4-bit count. The narrow count keeps every countdown short, so each expiry is observed at the exact tick that causes it. It also lets a zero reload and the top of the count range be exercised. Three devices are enough to show independent expiry of two timers while a third is held disabled or parked at zero. They also let the SMI enable mask select among several set status bits.

// File: rtl/idle_mon_pkg.sv
package idle_mon_pkg;

    // Activity sources that can reload a device countdown
    typedef struct packed {
        logic hit;
        logic dack;
        logic gpi;
    } act_t;

endpackage

// File: rtl/idle_mon_timer.sv
module idle_mon_timer
    import idle_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] reload_i,
    input  act_t             act_i,
    input  act_t             act_en_i,
    output logic             expire_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en_prev;
    } tmr_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_t tmr_d, tmr_q;
    logic load;

    always_comb begin
        tmr_d         = tmr_q;
        tmr_d.en_prev = en_i;
        expire_o      = 1'b0;
        load          = en_i && (!tmr_q.en_prev || (|(act_i & act_en_i)));
        if (load) begin
            tmr_d.cnt = reload_i;
        end else if (en_i && tick_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - ONE;
            expire_o  = (tmr_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: without a tick or reload the count holds
    p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load) |=> $stable(tmr_q.cnt));

    // R4: a reload event lands the programmed value
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (tmr_q.cnt == $past(reload_i)));

    // R8: an enabled count at zero stays there until reloaded
    p_stop_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tmr_q.cnt == '0 && !load) |=> (tmr_q.cnt == '0));

    // R9: disabled timer is frozen
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(tmr_q.cnt));

endmodule

// File: rtl/idle_mon_status.sv
module idle_mon_status #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] expire_i,
    input  logic [N_DEV-1:0] clr_i,
    input  logic [N_DEV-1:0] smi_en_i,
    output logic [N_DEV-1:0] sts_o,
    output logic             smi_o
);

    typedef struct packed {
        logic [N_DEV-1:0] sts;
    } sts_t;

    sts_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sts = (st_q.sts & ~clr_i) | expire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;
    assign smi_o = |(st_q.sts & smi_en_i);

    // R3: an expiry sets its status bit at the next edge
    p_set_on_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_i) |=> ((st_q.sts & $past(expire_i)) == $past(expire_i)));

    // R10: uncleared bits are sticky
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q.sts & ~clr_i)) |=>
            ((st_q.sts & $past(st_q.sts & ~clr_i)) == $past(st_q.sts & ~clr_i)));

endmodule

// File: rtl/idle_mon.sv
module idle_mon
    import idle_mon_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int CNT_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic [N_DEV-1:0]       tmr_en_i,
    input  logic [N_DEV*CNT_W-1:0] reload_i,
    input  logic [N_DEV-1:0]       smi_en_i,
    input  logic [N_DEV-1:0]       hit_i,
    input  logic                   hit_ext_ide_i,
    input  logic [N_DEV-1:0]       dack_i,
    input  logic [N_DEV-1:0]       dack_en_i,
    input  logic [N_DEV-1:0]       gpi_i,
    input  logic [N_DEV-1:0]       gpi_en_i,
    input  logic [N_DEV-1:0]       sts_clr_i,
    output logic [N_DEV-1:0]       idle_sts_o,
    output logic                   smi_o
);

    logic [N_DEV-1:0] expire;

    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
        act_t act, act_en;

        always_comb begin
            act.hit     = hit_i[k] && !hit_ext_ide_i;   // R6
            act.dack    = dack_i[k];
            act.gpi     = gpi_i[k];
            act_en.hit  = 1'b1;
            act_en.dack = dack_en_i[k];
            act_en.gpi  = gpi_en_i[k];
        end

        idle_mon_timer #(.CNT_W(CNT_W)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick_i),
            .en_i     (tmr_en_i[k]),
            .reload_i (reload_i[k*CNT_W +: CNT_W]),
            .act_i    (act),
            .act_en_i (act_en),
            .expire_o (expire[k])
        );
    end

    idle_mon_status #(.N_DEV(N_DEV)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire_i (expire),
        .clr_i    (sts_clr_i),
        .smi_en_i (smi_en_i),
        .sts_o    (idle_sts_o),
        .smi_o    (smi_o)
    );

endmodule

// File: tb/idle_mon_tb_top.sv
module idle_mon_tb_top;

    localparam int N  = 3;
    localparam int W  = 4;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [N-1:0] en = '0, smi_en = '0, hit = '0, dack = '0, dack_en = '0;
    logic [N-1:0] gpi = '0, gpi_en = '0, clr = '0;
    logic ext_ide = 1'b0;
    logic [W-1:0] rl [N];
    logic [N*W-1:0] reload;
    logic [N-1:0] sts;
    logic smi;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar k = 0; k < N; k++) begin : g_rl
        assign reload[k*W +: W] = rl[k];
    end

    idle_mon #(.N_DEV(N), .CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tmr_en_i(en),
        .reload_i(reload), .smi_en_i(smi_en), .hit_i(hit),
        .hit_ext_ide_i(ext_ide), .dack_i(dack), .dack_en_i(dack_en),
        .gpi_i(gpi), .gpi_en_i(gpi_en), .sts_clr_i(clr),
        .idle_sts_o(sts), .smi_o(smi)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic restart(input int d);
        en[d] = 1'b0; @(negedge clk);
        en[d] = 1'b1; @(negedge clk);
    endtask

    task automatic clear(input int d);
        clr[d] = 1'b1; @(negedge clk); clr[d] = 1'b0;
    endtask

    task automatic t_reset();
        check("reset sts", sts, 0);
        check("reset smi", smi, 0);
    endtask

    task automatic t_basic();
        rl[0] = 4'd3; smi_en = 3'b001;
        en[0] = 1'b1; @(negedge clk);
        cyc(6);
        check("R2 no tick no expiry", sts, 0);
        ticks(2);
        check("R1 not yet after 2", sts, 0);
        ticks(1);
        check("R3 expiry at 3rd tick", sts, 1);
        check("R11 smi enabled", smi, 1);
        smi_en = 3'b000; #1;
        check("R11 smi masked", smi, 0);
        smi_en = 3'b001;
        cyc(3);
        check("R10 sticky", sts, 1);
        clear(0);
        check("R10 cleared", sts, 0);
        ticks(5);
        check("R8 no re-expiry", sts, 0);
    endtask

    task automatic t_hit();
        restart(0); ticks(2);
        hit[0] = 1'b1; @(negedge clk); hit[0] = 1'b0;
        ticks(2);
        check("R4 hit reloads", sts, 0);
        ticks(1);
        check("R4 expiry after reload", sts, 1);
        clear(0);
    endtask

    task automatic t_dack_gpi();
        restart(0); ticks(2);
        dack[0] = 1'b1; gpi[0] = 1'b1; @(negedge clk); dack[0] = 1'b0; gpi[0] = 1'b0;
        ticks(1);
        check("R5 disabled sources ignored", sts, 1);
        clear(0);
        restart(0); ticks(2);
        dack_en[0] = 1'b1;
        dack[0] = 1'b1; @(negedge clk); dack[0] = 1'b0;
        ticks(2);
        check("R5 dack reload", sts, 0);
        ticks(1);
        check("R5 dack expiry", sts, 1);
        clear(0); dack_en[0] = 1'b0;
        restart(0); ticks(2);
        gpi_en[0] = 1'b1;
        gpi[0] = 1'b1; @(negedge clk); gpi[0] = 1'b0;
        ticks(2);
        check("R5 gpi reload", sts, 0);
        ticks(1);
        check("R5 gpi expiry", sts, 1);
        clear(0); gpi_en[0] = 1'b0;
    endtask

    task automatic t_ext_ide();
        restart(0); ticks(2);
        hit[0] = 1'b1; ext_ide = 1'b1; @(negedge clk);
        hit[0] = 1'b0; ext_ide = 1'b0;
        ticks(1);
        check("R6 ext ide hit ignored", sts, 1);
        clear(0);
    endtask

    task automatic t_prio();
        restart(0); ticks(2);
        hit[0] = 1'b1; tick = 1'b1; @(negedge clk);
        hit[0] = 1'b0; tick = 1'b0;
        ticks(2);
        check("R7 reload beats tick", sts, 0);
        ticks(1);
        check("R7 expiry after reload", sts, 1);
        clear(0);
    endtask

    task automatic t_freeze();
        restart(0); ticks(2);
        en[0] = 1'b0;
        ticks(5);
        check("R9 frozen no expiry", sts, 0);
        restart(0); ticks(3);
        check("R9 setup expiry", sts, 1);
        en[0] = 1'b0;
        ticks(3);
        check("R9 status kept", sts, 1);
        clear(0);
    endtask

    task automatic t_clr_set();
        rl[0] = 4'd1;
        restart(0); ticks(1);
        check("R10 setup", sts, 1);
        restart(0);
        tick = 1'b1; clr[0] = 1'b1; @(negedge clk);
        tick = 1'b0; clr[0] = 1'b0;
        check("R10 set wins over clear", sts, 1);
        clear(0);
        check("R10 clear after", sts, 0);
        en[0] = 1'b0;
    endtask

    task automatic t_zero_max();
        rl[2] = 4'd0; en[2] = 1'b1; @(negedge clk);
        ticks(20);
        check("R12 zero reload no expiry", sts, 0);
        en[2] = 1'b0;
        rl[1] = 4'd15; en[1] = 1'b1; @(negedge clk);
        ticks(14);
        check("R1 max not yet", sts, 0);
        ticks(1);
        check("R1 max expiry", sts, 2);
        clear(1); en[1] = 1'b0; @(negedge clk);
    endtask

    task automatic t_indep();
        rl[0] = 4'd4; rl[1] = 4'd2;
        en[0] = 1'b1; en[1] = 1'b1; @(negedge clk);
        ticks(2);
        check("R13 dev1 only", sts, 2);
        smi_en = 3'b001; #1;
        check("R11 dev1 masked", smi, 0);
        ticks(2);
        check("R13 both", sts, 3);
        smi_en = 3'b100; #1;
        check("R11 none enabled", smi, 0);
        smi_en = 3'b010; #1;
        check("R11 dev1 enabled", smi, 1);
    endtask

    initial begin
        for (int k = 0; k < N; k++) rl[k] = '0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_hit();
        t_dack_gpi();
        t_ext_ide();
        t_prio();
        t_freeze();
        t_clr_set();
        t_zero_max();
        t_indep();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule